// File: doc/BRIEF.md
# USB Device Address Deferred-Commit Register

This block keeps the 7-bit address that a USB device controller answers to. Software writes a new address over a simple register port. The write does not change the address at once. It only stages the value. The device keeps answering to its current address until the control endpoint logic signals that the current transfer has finished. At that point the staged value becomes the active address. A device normally receives its address in a SET_ADDRESS control request and must still finish that request, including its status stage, under the old address.

While a staged address waits to take effect, bit 7 of the register reads 1. The block clears this flag when the commit happens. For each incoming token, the block compares the token's address field with the active address. It raises a one-cycle match output that tells the rest of the device whether to respond.

Top module: `usb_addr_commit`

## Requirements
- R1: After reset, offset 0 reads 0x00 and the active address is 0, so a token with address 0 matches.
- R2: A write to offset 0 stages bits 6:0 of the write data. Reading offset 0 then returns the staged address in bits 6:0 and the value 1 in bit 7 (the pending flag). The read is combinational from the current register state.
- R3: Bit 7 of the write data has no effect. Every write to offset 0 sets the pending flag, whatever that bit holds.
- R4: The active address does not change until the end-of-transfer strobe arrives. Tokens are matched against the old address in the meantime.
- R5: An end-of-transfer strobe while the flag is set makes the staged address active at that clock edge and clears the flag.
- R6: When several writes happen before a commit, only the latest staged value becomes active on the next end-of-transfer strobe.
- R7: An end-of-transfer strobe while the flag is clear changes neither the active address nor the flag.
- R8: When a write and an end-of-transfer strobe fall in the same cycle, the commit takes the previously staged value. The flag stays at 1 for the new write.
- R9: The match output is 1 in exactly the cycle after a cycle in which the token valid input is 1 and the token address equals the active address. Otherwise it is 0.
- R10: A token that arrives in the same cycle as a commit is compared with the active address from before that commit.
- R11: Writes to any offset other than 0 have no effect, and reads of those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regOffset | input | 4 | Register offset for both reads and writes |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data: bit 7 is the pending flag, bits 6:0 are the staged address |
| xferDone | input | 1 | End-of-transfer strobe from the control endpoint |
| tokValid | input | 1 | Token address valid strobe |
| tokAddr | input | 7 | Address field of the incoming token |
| addrMatch | output | 1 | One-cycle indication that the token is addressed to this device |

## Verification
- **Read data:** it is combinational. A write or commit at one clock edge appears on the read data once that edge has passed.
- **Match output:** it is registered. A token presented before an edge produces its match one cycle later, compared with the active address that was in force before that edge.
- **Stimulus and sampling:** the bench drives inputs at the falling edge. A behavioural model advances at each rising edge, and every output is compared with the model at the next falling edge. Each result is therefore checked in the exact cycle it is due.

// File: rtl/usb_addr_pkg.sv
package usb_addr_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = ADDR_W + 1;
  localparam int OFF_W   = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic stageLoad;  // latch new write data into staged address
    logic commit;     // copy staged address into active address
  } ctrlStrobes_t;
endpackage

// File: rtl/usb_addr_ctrl.sv
module usb_addr_ctrl
  import usb_addr_pkg::*;
#(
  parameter int OFFSET_W = OFF_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [OFFSET_W-1:0] regOffset,
  input  logic                regWrEn,
  input  logic                xferDone,
  output ctrlStrobes_t        strobes,
  output logic                pending
);
  logic selAddrReg;
  assign selAddrReg = (regOffset == '0);

  always_comb begin
    strobes.stageLoad = regWrEn && selAddrReg;
    // commit only when something is waiting; takes the old staged value
    strobes.commit    = xferDone && pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  pending <= 1'b0;
    else if (strobes.stageLoad) pending <= 1'b1;
    else if (strobes.commit)    pending <= 1'b0;
  end

  // R2
  write_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regOffset == '0) |=> pending);
  // R5
  commit_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && pending && !(regWrEn && regOffset == '0)) |=> !pending);
  // R7
  idle_flag_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pending && !(regWrEn && regOffset == '0)) |=> !pending);
endmodule

// File: rtl/usb_addr_dp.sv
module usb_addr_dp
  import usb_addr_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int OFFSET_W = OFF_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic                pending,
  input  logic [OFFSET_W-1:0] regOffset,
  input  logic [AW:0]         regWrData,
  output logic [AW:0]         regRdData,
  input  logic                tokValid,
  input  logic [AW-1:0]       tokAddr,
  output logic                addrMatch
);
  logic [AW-1:0] stagedAddr;
  logic [AW-1:0] activeAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedAddr <= '0;
      activeAddr <= '0;
      addrMatch  <= 1'b0;
    end else begin
      if (strobes.stageLoad) stagedAddr <= regWrData[AW-1:0];
      if (strobes.commit)    activeAddr <= stagedAddr;
      addrMatch <= tokValid && (tokAddr == activeAddr);
    end
  end

  always_comb begin
    if (regOffset == '0) regRdData = {pending, stagedAddr};
    else                 regRdData = '0;
  end

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(activeAddr));
  // R5
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (activeAddr == $past(stagedAddr)));
  // R9
  match_needs_token_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tokValid |=> !addrMatch);
endmodule

// File: rtl/usb_addr_commit.sv
module usb_addr_commit
  import usb_addr_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int OFFSET_W = OFF_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [OFFSET_W-1:0] regOffset,
  input  logic                regWrEn,
  input  logic [AW:0]         regWrData,
  output logic [AW:0]         regRdData,
  input  logic                xferDone,
  input  logic                tokValid,
  input  logic [AW-1:0]       tokAddr,
  output logic                addrMatch
);
  ctrlStrobes_t strobes;
  logic         pending;

  usb_addr_ctrl #(.OFFSET_W(OFFSET_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regOffset(regOffset), .regWrEn(regWrEn),
    .xferDone(xferDone), .strobes(strobes), .pending(pending)
  );

  usb_addr_dp #(.AW(AW), .OFFSET_W(OFFSET_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pending(pending),
    .regOffset(regOffset), .regWrData(regWrData), .regRdData(regRdData),
    .tokValid(tokValid), .tokAddr(tokAddr), .addrMatch(addrMatch)
  );
endmodule

// File: tb/usb_addr_commit_bench.sv
module usb_addr_commit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regOffset = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       xferDone = 1'b0;
  logic       tokValid = 1'b0;
  logic [6:0] tokAddr = '0;
  logic       addrMatch;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  // behavioural reference state
  int mStaged = 0, mActive = 0, mPend = 0, mMatch = 0;

  always #4 clk = ~clk;

  usb_addr_commit u_usb_addr_commit (
    .clk(clk), .rstN(rstN), .regOffset(regOffset), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .xferDone(xferDone),
    .tokValid(tokValid), .tokAddr(tokAddr), .addrMatch(addrMatch)
  );

  always @(posedge clk) begin
    int nStaged, nActive, nPend, nMatch;
    if (!rstN) begin
      nStaged = 0; nActive = 0; nPend = 0; nMatch = 0;
    end else begin
      nStaged = mStaged; nActive = mActive; nPend = mPend;
      nMatch = (tokValid && tokAddr == mActive) ? 1 : 0;
      if (xferDone && mPend == 1) begin nActive = mStaged; nPend = 0; end
      if (regWrEn && regOffset == 0) begin nStaged = regWrData & 8'h7f; nPend = 1; end
    end
    mStaged = nStaged; mActive = nActive; mPend = nPend; mMatch = nMatch;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive, pass the edge, compare at falling edge
  task automatic cyc(string req, bit we = 0, int off = 0, int wd = 0,
                     bit done = 0, bit tv = 0, int ta = 0);
    curReq = req;
    regWrEn = we; regOffset = 4'(off); regWrData = 8'(wd);
    xferDone = done; tokValid = tv; tokAddr = 7'(ta);
    @(posedge clk);
    @(negedge clk);
    check(req, int'(regRdData), (off == 0) ? ((mPend << 7) | mStaged) : 0);
    check(req, int'(addrMatch), mMatch);
  endtask

  // probe the active address by a token
  task automatic probe(string req, int a, bit expect_match);
    cyc(req, 0, 0, 0, 0, 1, a);
    cyc(req);
    check(req, int'(addrMatch), 0);
    // directly verify via the previous cycle's model already compared
    if (expect_match) check(req, mActive, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    @(negedge clk);
    check("R1", int'(regRdData), 0);
    check("R1", int'(addrMatch), 0);
    cyc("R1", 0, 0, 0, 0, 1, 0);
    check("R1", int'(addrMatch), 1);
    // R2: write stages, flag set
    cyc("R2", 1, 0, 8'h15);
    check("R2", int'(regRdData), 8'h95);
    // R4: old address still active
    cyc("R4", 0, 0, 0, 0, 1, 0);
    check("R4", int'(addrMatch), 1);
    cyc("R4", 0, 0, 0, 0, 1, 8'h15);
    check("R4", int'(addrMatch), 0);
    // R5: commit
    cyc("R5", 0, 0, 0, 1);
    check("R5", int'(regRdData), 8'h15);
    cyc("R5", 0, 0, 0, 0, 1, 8'h15);
    check("R5", int'(addrMatch), 1);
    // R9: match lasts one cycle, needs valid
    cyc("R9", 0, 0, 0, 0, 0, 8'h15);
    check("R9", int'(addrMatch), 0);
    cyc("R9", 0, 0, 0, 0, 1, 8'h14);
    check("R9", int'(addrMatch), 0);
    // R7: done with nothing pending
    cyc("R7", 0, 0, 0, 1);
    check("R7", int'(regRdData), 8'h15);
    cyc("R7", 0, 0, 0, 0, 1, 8'h15);
    check("R7", int'(addrMatch), 1);
    // R3: bit 7 of write data ignored
    cyc("R3", 1, 0, 8'h22);
    check("R3", int'(regRdData), 8'hA2);
    cyc("R3", 1, 0, 8'h80 | 8'h33);
    check("R3", int'(regRdData), 8'hB3);
    // R6: latest write wins
    cyc("R6", 1, 0, 8'h41);
    cyc("R6", 0, 0, 0, 1);
    cyc("R6", 0, 0, 0, 0, 1, 8'h41);
    check("R6", int'(addrMatch), 1);
    // R8 + R10: write and commit same cycle, token in same cycle
    cyc("R8", 1, 0, 8'h50);
    cyc("R8", 1, 0, 8'h60, 1, 1, 8'h41);
    check("R10", int'(addrMatch), 1);
    check("R8", int'(regRdData), 8'hE0);
    cyc("R8", 0, 0, 0, 0, 1, 8'h50);
    check("R8", int'(addrMatch), 1);
    cyc("R8", 0, 0, 0, 1, 1, 8'h50);
    check("R10", int'(addrMatch), 1);
    cyc("R8", 0, 0, 0, 0, 1, 8'h60);
    check("R8", int'(addrMatch), 1);
    // R11: other offsets
    cyc("R11", 1, 3, 8'h7f);
    check("R11", int'(regRdData), 0);
    cyc("R11", 0, 0);
    check("R11", int'(regRdData), 8'h60);
    cyc("R11", 0, 0, 0, 1, 1, 8'h60);
    check("R11", int'(addrMatch), 1);
    probe("R9", 8'h60, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL watchdog %s expired", curReq);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule